// File: doc/BRIEF.md
# Serial Flash Controller Interrupt Aggregator

This block gathers the interrupt sources of a serial flash controller into one status word and raises one interrupt line. Four sources are live flags computed every cycle from the transmit and receive FIFO fill levels. Two of those four are compared against software-programmed thresholds, and two come from a fixed full-depth comparison. Two further sources are error events (receive overflow, transmit underflow) that stay set until software clears them by writing a one to their position.

The enable mask cannot be written as a whole. A write of ones to the enable-set register turns mask bits on, and a write of ones to the enable-clear register turns them off. The mask itself can only be read. The interrupt output is the registered OR of the status bits that are enabled.

Software reaches every register through a plain 32-bit port: one write strobe, a byte address and write data, with read data returned combinationally for the presented address. The FIFOs and the serial shifter live outside the block and appear only as level and event inputs.

Top module: `sflash_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0, both error bits (bit 0 and bit 6 of status) read 0, both thresholds read 1, and the interrupt output is low.
- R2: Status bit 2 reads 1 exactly while the transmit level is below the transmit threshold. Status bit 4 reads 1 exactly while the receive level is at or above the receive threshold.
- R3: Status bit 3 reads 1 while the transmit level equals DEPTH, and bit 5 reads 1 while the receive level equals DEPTH.
- R4: A receive push while the receive level equals DEPTH sets status bit 0, which then stays 1 until cleared.
- R5: A shifter data request while the transmit level is 0 and a transfer is active sets status bit 6. The same request with no active transfer leaves bit 6 at 0.
- R6: Writing the status register (address 0x04) clears each error bit whose write-data bit is 1. A zero leaves it unchanged. A new event in the same cycle as the clear keeps the bit at 1.
- R7: Writes to status have no effect on the live bits 2 to 5.
- R8: A write to address 0x08 sets the mask bits where write data is 1. A write to address 0x0C clears them. Only bits 0 and 2 to 6 exist, so mask bit 1 and bits 31:7 always read 0.
- R9: The mask at address 0x10 is read-only, and a write there leaves it unchanged.
- R10: Transmit and receive thresholds are read/write at 0x28 and 0x2C and hold the low bits of the written data, wide enough for DEPTH.
- R11: The interrupt output equals the OR of (status AND mask) as it stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| tx_level | input | LW | Transmit FIFO fill level |
| rx_level | input | LW | Receive FIFO fill level |
| rx_push | input | 1 | A received byte is being pushed |
| tx_pull | input | 1 | Shifter requests the next transmit byte |
| xfer_active | input | 1 | A serial transfer is in progress |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is an error event and its clear landing in the same cycle. The bench gets there by holding the receive level at DEPTH and raising the push pulse in the same clock as the status write, then reading the bit back through the port. The underflow condition needs a transfer-active qualifier, so the bench issues the same request twice, once with the qualifier low and once with it high. That shows the qualifier gates the event.

// File: rtl/sflash_irq_ctrl.sv
module sflash_irq_ctrl #(
  parameter int DEPTH = 64,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_level,
  input  logic          rx_push,
  input  logic          tx_pull,
  input  logic          xfer_active,
  output logic          irq
);
  localparam logic [7:0] A_STAT = 8'h04, A_ENA = 8'h08, A_DIS = 8'h0C,
                         A_MASK = 8'h10, A_TTHR = 8'h28, A_RTHR = 8'h2C;
  localparam logic [6:0] VALID = 7'b111_1101;
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [LW-1:0] tthr_q, rthr_q;
  logic [6:0]    mask_q, status;
  logic          ovf_q, unf_q;
  logic          ovf_ev, unf_ev;

  assign ovf_ev = rx_push && (rx_level == FULL);
  assign unf_ev = tx_pull && xfer_active && (tx_level == '0);

  assign status = {unf_q, rx_level == FULL, rx_level >= rthr_q,
                   tx_level == FULL, tx_level < tthr_q, 1'b0, ovf_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
      mask_q <= '0;
      tthr_q <= LW'(1);
      rthr_q <= LW'(1);
      irq    <= 1'b0;
    end else begin
      ovf_q <= ovf_ev | (ovf_q & ~(wr_en && addr == A_STAT && wdata[0]));
      unf_q <= unf_ev | (unf_q & ~(wr_en && addr == A_STAT && wdata[6]));
      if (wr_en && addr == A_ENA) mask_q <= mask_q | (wdata[6:0] & VALID);
      if (wr_en && addr == A_DIS) mask_q <= mask_q & ~wdata[6:0];
      if (wr_en && addr == A_TTHR) tthr_q <= wdata[LW-1:0];
      if (wr_en && addr == A_RTHR) rthr_q <= wdata[LW-1:0];
      irq <= |(status & mask_q);
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_STAT: rdata[6:0]    = status;
      A_MASK: rdata[6:0]    = mask_q;
      A_TTHR: rdata[LW-1:0] = tthr_q;
      A_RTHR: rdata[LW-1:0] = rthr_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/sflash_irq_ctrl_chk.sv
module sflash_irq_ctrl_chk #(
  parameter int DEPTH = 64,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [7:0]    addr,
  input logic [31:0]   wdata,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          rx_push,
  input logic          tx_pull,
  input logic          xfer_active,
  input logic [6:0]    status,
  input logic [6:0]    mask_q,
  input logic          irq
);
  p_overflow_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_level == LW'(DEPTH)) |=> status[0]);

  p_underflow_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pull && xfer_active && tx_level == '0) |=> status[6]);

  p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && addr == 8'h04) && status[0]) |=> status[0]);

  p_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h08) |=> ((mask_q & $past(wdata[6:0]) & 7'b111_1101)
                                   == ($past(wdata[6:0]) & 7'b111_1101)));

  p_mask_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h0C) |=> ((mask_q & $past(wdata[6:0])) == 7'd0));

  p_mask_bit1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q[1]);

  p_mask_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h10) |=> $stable(mask_q));

  p_irq_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & mask_q)) |=> irq);

  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status & mask_q)) |=> !irq);
endmodule

bind sflash_irq_ctrl sflash_irq_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .tx_level(tx_level), .rx_level(rx_level), .rx_push(rx_push),
  .tx_pull(tx_pull), .xfer_active(xfer_active), .status(status),
  .mask_q(mask_q), .irq(irq)
);

// File: tb/sflash_irq_ctrl_test.sv
module sflash_irq_ctrl_test;
  localparam int DEPTH = 64;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, wr_en = 0, rx_push = 0, tx_pull = 0, xfer_active = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [LW-1:0] tx_level = 0, rx_level = 0;
  logic irq;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  sflash_irq_ctrl #(.DEPTH(DEPTH)) uut (.*);

  // {tx_level, rx_level, tx_thr, rx_thr, expected {rx_full, rx_ne, tx_full, tx_nf}}
  localparam int NV = 7;
  localparam logic [35:0] VEC [NV] = '{
    {8'd0,  8'd0,  8'd1,  8'd1,  4'b0001},
    {8'd1,  8'd1,  8'd1,  8'd1,  4'b0100},
    {8'd64, 8'd64, 8'd1,  8'd1,  4'b1110},
    {8'd10, 8'd9,  8'd11, 8'd10, 4'b0001},
    {8'd11, 8'd10, 8'd11, 8'd10, 4'b0100},
    {8'd63, 8'd63, 8'd64, 8'd64, 4'b0001},
    {8'd64, 8'd0,  8'd64, 8'd1,  4'b0010}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  logic [31:0] v;

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h10, v); chk("R1 mask", v, 0);
    rd(8'h04, v); chk("R1 status", v, 32'h04);
    rd(8'h28, v); chk("R1 tthr", v, 1);
    rd(8'h2C, v); chk("R1 rthr", v, 1);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 R3 R10 table
    for (int i = 0; i < NV; i++) begin
      wr(8'h28, {24'd0, VEC[i][19:12]});
      wr(8'h2C, {24'd0, VEC[i][11:4]});
      tx_level = LW'(VEC[i][35:28]);
      rx_level = LW'(VEC[i][27:20]);
      rd(8'h28, v); chk("R10 tthr", v, {24'd0, VEC[i][19:12]});
      rd(8'h04, v); chk("R2 R3 live", {28'd0, v[5:2]}, {28'd0, VEC[i][3:0]});
    end
    wr(8'h28, 1); wr(8'h2C, 1);
    tx_level = 5; rx_level = 0;

    // R7 write to live bits no effect
    wr(8'h04, 32'hFFFF_FFFF);
    tx_level = 0;
    rd(8'h04, v); chk("R7 live", v, 32'h04);

    // R4 overflow, only when full
    rx_level = 10;
    @(negedge clk); rx_push = 1; @(negedge clk); rx_push = 0;
    rd(8'h04, v); chk("R4 no ovf", {31'd0, v[0]}, 0);
    rx_level = 64;
    @(negedge clk); rx_push = 1; @(negedge clk); rx_push = 0;
    rx_level = 0;
    repeat (3) @(negedge clk);
    rd(8'h04, v); chk("R4 ovf sticky", {31'd0, v[0]}, 1);
    chk("R11 masked", {31'd0, irq}, 0);

    // R8 enable, R11 irq
    wr(8'h08, 32'h01);
    rd(8'h10, v); chk("R8 ena", v, 1);
    @(negedge clk);
    chk("R11 irq up", {31'd0, irq}, 1);

    // R6 write zero keeps, write one clears
    wr(8'h04, 32'h0);
    rd(8'h04, v); chk("R6 zero keeps", {31'd0, v[0]}, 1);
    wr(8'h04, 32'h1);
    rd(8'h04, v); chk("R6 clear", {31'd0, v[0]}, 0);
    @(negedge clk);
    chk("R11 irq down", {31'd0, irq}, 0);

    // R6 set wins over same-cycle clear
    rx_level = 64;
    @(negedge clk); rx_push = 1; wr_en = 1; addr = 8'h04; wdata = 1;
    @(negedge clk); rx_push = 0; wr_en = 0; rx_level = 0;
    rd(8'h04, v); chk("R6 set wins", {31'd0, v[0]}, 1);
    wr(8'h04, 1);

    // R5 underflow needs active transfer
    tx_level = 0;
    @(negedge clk); tx_pull = 1; @(negedge clk); tx_pull = 0;
    rd(8'h04, v); chk("R5 idle no unf", {31'd0, v[6]}, 0);
    xfer_active = 1;
    @(negedge clk); tx_pull = 1; @(negedge clk); tx_pull = 0; xfer_active = 0;
    rd(8'h04, v); chk("R5 unf", {31'd0, v[6]}, 1);
    wr(8'h04, 32'h40);
    rd(8'h04, v); chk("R6 unf clear", {31'd0, v[6]}, 0);

    // R8 all ones, bit1 absent; R9 read-only
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R8 valid bits", v, 32'h7D);
    wr(8'h10, 32'h0);
    rd(8'h10, v); chk("R9 ro", v, 32'h7D);
    wr(8'h0C, 32'h7C);
    rd(8'h10, v); chk("R8 dis", v, 32'h01);

    // R11 live source: tx not-full with mask bit 2
    wr(8'h08, 32'h04);
    @(negedge clk);
    chk("R11 live irq", {31'd0, irq}, 1);
    tx_level = 20;
    @(negedge clk); @(negedge clk);
    chk("R11 live irq off", {31'd0, irq}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule